// File: doc/BRIEF.md
# Byte-serial register command receiver

This block turns a stream of bytes on an 8-bit bus into parallel register-write commands. Each command is a frame of six bytes sent on consecutive clock cycles. A strobe is raised with the first byte only. The first two bytes form a 16-bit address, sent low byte first. The next four bytes form a 32-bit data word, sent least significant byte first.

When the sixth byte arrives, the block compares the assembled address with a base address under a mask. Only the masked bits take part in the comparison. On a hit it presents three things: the low address bits, which select one of 16 registers; the data word; and a one-cycle write enable. Register decoding downstream uses these outputs directly. A frame whose address misses is dropped. A strobe in the middle of a frame throws away the partial frame and starts a new one.

Top module: `byte_cmd_deser`

## Requirements
- R1: After reset, `reg_we_o` is 0, `reg_sel_o` and `reg_data_o` are 0, and no partial frame is in progress.
- R2: A frame is six bytes on consecutive cycles. The address is byte0 (bits 7:0) and byte1 (bits 15:8). The data word is byte2 (bits 7:0) through byte5 (bits 31:24).
- R3: A frame is accepted only when (address & 0x03F0) == (0x0120 & 0x03F0). Address bits outside the mask are ignored, so 0xF12A is accepted and 0x0130 is not.
- R4: On acceptance, `reg_sel_o` equals address bits 3:0 and `reg_data_o` equals the assembled data word.
- R5: `reg_we_o` is high for exactly one cycle, the cycle after the sixth byte is sampled, and only for an accepted frame.
- R6: A frame whose address misses produces no write, and `reg_sel_o` and `reg_data_o` keep their previous values.
- R7: A strobe during a frame, including on the sixth byte, discards the partial frame without a write. The byte sent with that strobe is taken as byte0 of a new frame.
- R8: Bytes presented without a strobe while no frame is in progress are ignored.
- R9: `reg_sel_o` and `reg_data_o` hold their values until the next accepted frame.
- R10: A strobe in the cycle right after a sixth byte starts a new frame. Back-to-back frames are each written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| cmd_byte_i | input | 8 | Serial command byte |
| cmd_stb_i | input | 1 | High with the first byte of a frame |
| reg_sel_o | output | 4 | Register select, the low address bits |
| reg_data_o | output | 32 | Write data |
| reg_we_o | output | 1 | One-cycle write enable |

## Verification
The assertions check four properties on every cycle. The write enable never lasts two cycles. It only follows a sixth byte whose address hit. A miss on the sixth byte is never followed by a write. The select and data outputs stay still whenever no write occurs. The counter also checks that a strobe always restarts at the second byte position and that a bus byte with no frame in progress never starts a frame.

Only the bench scenarios can show the byte-to-bit order of the assembled word and the masked comparison against concrete addresses. They also cover the discarding of partial frames cut by a strobe and the handling of back-to-back frames. For these, a queue-based model is compared with the outputs on every clock.

// File: rtl/byte_cmd_pkg.sv
package byte_cmd_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cmd_byte_counter.sv
module cmd_byte_counter
    import byte_cmd_pkg::*;
#(
    parameter int FRAME_BYTES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_i,
    output logic take_o,
    output logic [$clog2(FRAME_BYTES)-1:0] lane_o,
    output logic last_o
);
    localparam int POS_W = $clog2(FRAME_BYTES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);

    typedef struct packed {
        logic             busy;
        logic [POS_W-1:0] pos;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        take_o = stb_i | cnt_q.busy;
        lane_o = stb_i ? '0 : cnt_q.pos;
        last_o = take_o && (lane_o == LAST_POS);
        if (stb_i) begin
            cnt_d.busy = 1'b1;
            cnt_d.pos  = POS_W'(1);
        end else if (cnt_q.busy) begin
            if (cnt_q.pos == LAST_POS) begin
                cnt_d.busy = 1'b0;
                cnt_d.pos  = '0;
            end else begin
                cnt_d.pos = cnt_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        stb_i |=> (cnt_q.busy && cnt_q.pos == POS_W'(1)));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!stb_i && !cnt_q.busy) |=> !cnt_q.busy);
endmodule

// File: rtl/cmd_frame_collect.sv
module cmd_frame_collect
    import byte_cmd_pkg::*;
#(
    parameter int FRAME_BYTES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  logic [$clog2(FRAME_BYTES)-1:0] lane_i,
    input  byte_t byte_i,
    output logic [FRAME_BYTES*BYTE_W-1:0] frame_o
);
    localparam int POS_W = $clog2(FRAME_BYTES);

    for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_lane
        byte_t lane_d, lane_q;
        logic  hit;

        always_comb begin
            hit    = take_i && (lane_i == POS_W'(g));
            lane_d = hit ? byte_i : lane_q;
            frame_o[g*BYTE_W +: BYTE_W] = lane_d;
        end

        always_ff @(posedge clk or posedge rst) begin
            if (rst) lane_q <= '0;
            else     lane_q <= lane_d;
        end
    end
endmodule

// File: rtl/cmd_addr_match.sv
module cmd_addr_match #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    parameter logic [15:0] ADDR_MASK = 16'h03F0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam logic [ADDR_W-1:0] MASK_W = ADDR_W'(ADDR_MASK);
    localparam logic [ADDR_W-1:0] BASE_M = ADDR_W'(BASE_ADDR) & MASK_W;

    always_comb hit_o = ((addr_i & MASK_W) == BASE_M);
endmodule

// File: rtl/byte_cmd_deser.sv
module byte_cmd_deser
    import byte_cmd_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR  = 16'h0120,
    parameter logic [15:0] ADDR_MASK  = 16'h03F0,
    parameter int          ADDR_BYTES = 2,
    parameter int          DATA_BYTES = 4,
    parameter int          SEL_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [7:0]                   cmd_byte_i,
    input  logic                         cmd_stb_i,
    output logic [SEL_W-1:0]             reg_sel_o,
    output logic [DATA_BYTES*BYTE_W-1:0] reg_data_o,
    output logic                         reg_we_o
);
    localparam int ADDR_W      = ADDR_BYTES * BYTE_W;
    localparam int DATA_W      = DATA_BYTES * BYTE_W;
    localparam int FRAME_BYTES = ADDR_BYTES + DATA_BYTES;
    localparam int POS_W       = $clog2(FRAME_BYTES);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] data;
        logic              we;
    } out_t;

    out_t out_d, out_q;

    logic                          take_w, last_w, hit_w;
    logic [POS_W-1:0]              lane_w;
    logic [FRAME_BYTES*BYTE_W-1:0] frame_w;
    logic [ADDR_W-1:0]             addr_w;
    logic [DATA_W-1:0]             data_w;

    cmd_byte_counter #(.FRAME_BYTES(FRAME_BYTES)) u_cnt (
        .clk(clk), .rst(rst), .stb_i(cmd_stb_i),
        .take_o(take_w), .lane_o(lane_w), .last_o(last_w)
    );

    cmd_frame_collect #(.FRAME_BYTES(FRAME_BYTES)) u_col (
        .clk(clk), .rst(rst), .take_i(take_w), .lane_i(lane_w),
        .byte_i(cmd_byte_i), .frame_o(frame_w)
    );

    assign addr_w = frame_w[ADDR_W-1:0];
    assign data_w = frame_w[ADDR_W +: DATA_W];

    cmd_addr_match #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ADDR_MASK(ADDR_MASK)) u_match (
        .addr_i(addr_w), .hit_o(hit_w)
    );

    always_comb begin
        out_d    = out_q;
        out_d.we = 1'b0;
        if (last_w && hit_w) begin
            out_d.sel  = addr_w[SEL_W-1:0];
            out_d.data = data_w;
            out_d.we   = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign reg_sel_o  = out_q.sel;
    assign reg_data_o = out_q.data;
    assign reg_we_o   = out_q.we;

    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> !reg_we_o);

    p_we_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_we_o) |-> ($past(last_w) && $past(hit_w)));

    p_miss_r6: assert property (@(posedge clk) disable iff (rst)
        (last_w && !hit_w) |=> !reg_we_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !reg_we_o |-> ($stable(reg_sel_o) && $stable(reg_data_o)));
endmodule

// File: tb/byte_cmd_deser_bench.sv
module byte_cmd_deser_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_byte_i = '0;
    logic        cmd_stb_i = 1'b0;
    logic [3:0]  reg_sel_o;
    logic [31:0] reg_data_o;
    logic        reg_we_o;

    int checks = 0;
    int bad = 0;
    int we_seen = 0;
    string cur_req = "R1";

    logic [7:0]  q[$];
    logic        exp_we = 1'b0;
    logic [3:0]  exp_sel = '0;
    logic [31:0] exp_data = '0;

    always #2 clk = ~clk;

    byte_cmd_deser u_byte_cmd_deser (
        .clk(clk), .rst(rst), .cmd_byte_i(cmd_byte_i), .cmd_stb_i(cmd_stb_i),
        .reg_sel_o(reg_sel_o), .reg_data_o(reg_data_o), .reg_we_o(reg_we_o)
    );

    // reference model: a byte queue per frame
    always @(posedge clk) begin
        logic [15:0] a;
        logic [31:0] d;
        exp_we = 1'b0;
        if (rst) begin
            q.delete();
            exp_sel = '0;
            exp_data = '0;
        end else begin
            if (cmd_stb_i) begin
                q.delete();
                q.push_back(cmd_byte_i);
            end else if (q.size() > 0) begin
                q.push_back(cmd_byte_i);
            end
            if (q.size() == 6) begin
                a = {q[1], q[0]};
                d = {q[5], q[4], q[3], q[2]};
                if ((a & 16'h03F0) == 16'h0120) begin
                    exp_sel = a[3:0];
                    exp_data = d;
                    exp_we = 1'b1;
                end
                q.delete();
            end
        end
    end

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "cycle we", 64'(reg_we_o), 64'(exp_we));
            check(cur_req, "cycle sel", 64'(reg_sel_o), 64'(exp_sel));
            check(cur_req, "cycle data", 64'(reg_data_o), 64'(exp_data));
            if (reg_we_o) we_seen++;
        end
    end

    task automatic drive(logic [7:0] b, logic s);
        @(negedge clk);
        cmd_byte_i = b;
        cmd_stb_i = s;
    endtask

    task automatic frame(logic [15:0] a, logic [31:0] d);
        drive(a[7:0], 1'b1);
        drive(a[15:8], 1'b0);
        drive(d[7:0], 1'b0);
        drive(d[15:8], 1'b0);
        drive(d[23:16], 1'b0);
        drive(d[31:24], 1'b0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(8'h00, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "we", 64'(reg_we_o), 0);
        check("R1", "sel", 64'(reg_sel_o), 0);
        check("R1", "data", 64'(reg_data_o), 0);

        // R2 / R4 / R5 byte order and outputs
        cur_req = "R2";
        frame(16'h0125, 32'hA1B2C3D4);
        drive(8'h00, 1'b0);
        check("R5", "we after sixth byte", 64'(reg_we_o), 1);
        check("R4", "sel", 64'(reg_sel_o), 64'h5);
        check("R2", "data order", 64'(reg_data_o), 64'hA1B2C3D4);
        drive(8'h00, 1'b0);
        check("R5", "we one cycle", 64'(reg_we_o), 0);

        // R3 mask ignores high bits, boundary of group
        cur_req = "R3";
        frame(16'hF12A, 32'h11223344);
        drive(8'h00, 1'b0);
        check("R3", "masked high bits accepted", 64'(reg_we_o), 1);
        check("R3", "sel", 64'(reg_sel_o), 64'hA);
        frame(16'h012F, 32'h55667788);
        drive(8'h00, 1'b0);
        check("R3", "top of group", 64'(reg_sel_o), 64'hF);

        // R6 mismatch: no write, outputs held (R9)
        cur_req = "R6";
        frame(16'h0130, 32'hDEADBEEF);
        drive(8'h00, 1'b0);
        check("R6", "no we on miss", 64'(reg_we_o), 0);
        check("R6", "data held", 64'(reg_data_o), 64'h55667788);
        frame(16'h0220, 32'h0BADF00D);
        idle(5);
        check("R9", "sel held", 64'(reg_sel_o), 64'hF);
        check("R9", "data held", 64'(reg_data_o), 64'h55667788);

        // R8 idle bytes ignored
        cur_req = "R8";
        base = we_seen;
        drive(8'h20, 1'b0); drive(8'h01, 1'b0); drive(8'h99, 1'b0);
        drive(8'h99, 1'b0); drive(8'h99, 1'b0); drive(8'h99, 1'b0);
        idle(3);
        check("R8", "no write from unstrobed bytes", 64'(we_seen - base), 0);
        check("R8", "data", 64'(reg_data_o), 64'h55667788);

        // R7 restart mid-frame, and at the sixth byte
        cur_req = "R7";
        base = we_seen;
        drive(8'h21, 1'b1); drive(8'h01, 1'b0); drive(8'hEE, 1'b0);
        frame(16'h0123, 32'hCAFE0001);
        idle(2);
        check("R7", "one write after restart", 64'(we_seen - base), 1);
        check("R7", "data of new frame", 64'(reg_data_o), 64'hCAFE0001);
        base = we_seen;
        drive(8'h24, 1'b1); drive(8'h01, 1'b0); drive(8'h01, 1'b0);
        drive(8'h02, 1'b0); drive(8'h03, 1'b0);
        frame(16'h0126, 32'h00C0FFEE);
        idle(2);
        check("R7", "restart on sixth byte", 64'(we_seen - base), 1);
        check("R7", "sel", 64'(reg_sel_o), 64'h6);

        // R10 back-to-back frames
        cur_req = "R10";
        base = we_seen;
        frame(16'h0121, 32'h10101010);
        frame(16'h0122, 32'h20202020);
        frame(16'h0127, 32'h30303030);
        idle(2);
        check("R10", "three writes", 64'(we_seen - base), 3);
        check("R10", "last data", 64'(reg_data_o), 64'h30303030);

        idle(2);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule